// File: doc/BRIEF.md
# Multi-Mode Capture/Reload Timer

This block is a counter that can run in five modes: auto-reload, capture, baud-rate generation, up/down auto-reload and clock-out. All five modes share one counter and one capture/reload register, both of width `CNT_W`. A control byte and a two-bit mode field select the mode. The control byte also holds the run bit, the count-source select, the external-trigger enable and the two sticky flags. The counter can count internal machine-cycle ticks or falling edges on the count pin.

The external trigger pin has a different job in each mode. In capture mode it is a capture strobe. In auto-reload mode it is a reload strobe. In up/down mode it is a direction level. In baud-rate and clock-out modes it only sets a flag.

The block produces four outputs for other logic:
- an overflow flag and an external flag;
- a one-cycle overflow pulse for a serial port;
- a clock-out pin that toggles on each overflow;
- an interrupt request.

The host can load the counter and the reload register directly.

Top module: `capreload_timer`

## Requirements
- R1: Control byte bits:
  - 7: overflow flag
  - 6: external flag
  - 5: receive-clock select
  - 4: transmit-clock select
  - 3: external enable
  - 2: run
  - 1: count-source select (1 = pin edges)
  - 0: capture select

  Mode field bits: bit 0 is down-count enable and bit 1 is clock-out enable. The mode is chosen in this priority order:
  1. clock-out, if clock-out enable is set;
  2. otherwise baud-rate, if either clock select is set;
  3. otherwise capture, if capture select is set;
  4. otherwise up/down, if down-count enable is set;
  5. otherwise auto-reload.
- R2: In auto-reload mode, an up-count past all-ones loads the counter from the reload register and sets the overflow flag.
- R3: In auto-reload mode with external enable set, a trigger falling edge loads the counter from the reload register and sets the external flag. A rising edge does nothing.
- R4: In capture mode with external enable set, a trigger falling edge copies the live counter into the capture register and sets the external flag. An overflow sets the overflow flag, and the counter continues from zero.
- R5: In baud-rate mode with internal counting, each tick adds `FAST_MULT` (6). An overflow loads the reload value plus the carried-over excess and gives a one-cycle `serialTick` in the next cycle. The overflow flag is not set. A trigger falling edge sets the external flag but does not reload.
- R6: With count-source select at 1, the counter advances by one for each falling edge on the count pin. Ticks and rising edges are ignored.
- R7: In up/down mode, a high trigger level counts up with reload on overflow. A low level counts down. When the decremented value is below the reload value, the counter loads all-ones and the overflow flag is set. Trigger edges have no effect in this mode.
- R8: In up/down mode, every overflow or underflow toggles the external flag, and the external flag does not drive the interrupt.
- R9: In clock-out mode, the counter runs with reload and `serialTick` pulses on each overflow. `clkOut` toggles on each overflow only while count-source select is 0. The overflow flag is not set.
- R10: A trigger or count edge that is detected in the same cycle as a write that changes the mode or the run bit is discarded.
- R11: With the run bit at 0 the counter holds, but trigger-driven reload, capture and flag setting still take effect.
- R12: Both flags reset to 0. They stay set until a control write changes them; a write of 1 sets a flag and a write of 0 clears it. A hardware set in the same cycle as a software clear wins.
- R13: `irq` equals `irqEn` AND (overflow flag OR external flag), with the external flag left out in up/down mode.
- R14: A host counter load takes precedence over counting and reload. A host reload-register write takes effect the next cycle unless a capture happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Control byte write strobe |
| ctlWrData | input | 8 | Control byte value |
| modeWrEn | input | 1 | Mode field write strobe |
| modeWrData | input | 2 | Mode field value |
| cntWrEn | input | 1 | Counter load strobe |
| cntWrData | input | CNT_W | Counter load value |
| capWrEn | input | 1 | Reload register write strobe |
| capWrData | input | CNT_W | Reload register value |
| tick | input | 1 | Machine-cycle tick |
| t2Pin | input | 1 | Count source pin (asynchronous) |
| t2exPin | input | 1 | External trigger pin (asynchronous) |
| irqEn | input | 1 | Interrupt enable |
| count | output | CNT_W | Live counter value |
| capVal | output | CNT_W | Capture/reload register |
| ovfFlag | output | 1 | Sticky overflow flag |
| extFlag | output | 1 | External flag |
| serialTick | output | 1 | One-cycle overflow pulse toward the serial port |
| clkOut | output | 1 | Clock-out toggle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `CNT_W` = 16, `SYNC_STAGES` = 2 and `FAST_MULT` = 6.

Because the counter can be loaded directly, every overflow and underflow is reached within a few ticks. A preload near all-ones with a step of six exercises the excess carried into the reloaded value.

With two synchronizer stages, a pin change acts on the third clock edge. This fixed latency lets the bench place a trigger edge in exactly the same cycle as a run-bit write.

// File: rtl/capreload_timer_pkg.sv
package capreload_timer_pkg;

  // Control byte bit positions
  localparam int CTL_OVF    = 7;
  localparam int CTL_EXT    = 6;
  localparam int CTL_RX     = 5;
  localparam int CTL_TX     = 4;
  localparam int CTL_EXEN   = 3;
  localparam int CTL_RUN    = 2;
  localparam int CTL_CNTSEL = 1;
  localparam int CTL_CAP    = 0;

  // Mode field bit positions
  localparam int MOD_DN  = 0;
  localparam int MOD_OUT = 1;
  localparam int MOD_W   = 2;

  typedef enum logic [2:0] {
    TM_RELOAD,
    TM_CAPTURE,
    TM_BAUD,
    TM_UPDOWN,
    TM_CLKOUT
  } tmrMode_e;

  typedef struct packed {
    logic busLoad;
    logic extReload;
    logic extCapture;
    logic step;
    logic fastStep;
    logic downDir;
    logic wrapZero;
  } dpCmd_t;

  typedef struct packed {
    logic ovf;
    logic unf;
  } dpEvt_t;

  function automatic tmrMode_e decodeMode(input logic rxSel, input logic txSel,
                                          input logic capSel, input logic dnEn,
                                          input logic outEn);
    if (outEn)              return TM_CLKOUT;
    else if (rxSel | txSel) return TM_BAUD;
    else if (capSel)        return TM_CAPTURE;
    else if (dnEn)          return TM_UPDOWN;
    else                    return TM_RELOAD;
  endfunction

endpackage

// File: rtl/crt_sync.sv
module crt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= 1'b1;
          else       pipe[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[i] <= 1'b1;
          else       pipe[i] <= pipe[i-1];
        end
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/crt_datapath.sv
module crt_datapath
  import capreload_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int FAST_MULT = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [CNT_W-1:0] busVal,
  input  logic             capWrEn,
  input  logic [CNT_W-1:0] capWrVal,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output dpEvt_t           evt
);
  localparam logic [CNT_W:0] INC_FAST = (CNT_W+1)'(FAST_MULT);
  localparam logic [CNT_W:0] INC_ONE  = (CNT_W+1)'(1);

  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] dec;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    sum     = {1'b0, count} + (cmd.fastStep ? INC_FAST : INC_ONE);
    dec     = count - CNT_W'(1);
    cntNext = count;
    evt     = '0;
    if (cmd.busLoad) begin
      cntNext = busVal;
    end else if (cmd.extReload) begin
      cntNext = capVal;
    end else if (cmd.step) begin
      if (cmd.downDir) begin
        if (dec < capVal) begin
          cntNext = '1;
          evt.unf = 1'b1;
        end else begin
          cntNext = dec;
        end
      end else if (sum[CNT_W]) begin
        evt.ovf = 1'b1;
        cntNext = cmd.wrapZero ? sum[CNT_W-1:0] : capVal + sum[CNT_W-1:0];
      end else begin
        cntNext = sum[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      capVal <= '0;
    end else begin
      count <= cntNext;
      if (cmd.extCapture) capVal <= count;
      else if (capWrEn)   capVal <= capWrVal;
    end
  end
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl
  import capreload_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  input  logic             modeWrEn,
  input  logic [MOD_W-1:0] modeWrData,
  input  logic             cntWrEn,
  input  logic             tick,
  input  logic             t2Pin,
  input  logic             t2exPin,
  input  logic             irqEn,
  input  dpEvt_t           evt,
  output dpCmd_t           cmd,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             serialTick,
  output logic             clkOut,
  output logic             irq
);
  logic rxSel, txSel, extEn, run, cntSel, capSel, dnEn, outEn;
  logic t2Cur, exCur, t2Prev, exPrev;

  crt_sync #(.STAGES(SYNC_STAGES)) u_syncT2 (.clk(clk), .rstN(rstN), .din(t2Pin),   .dout(t2Cur));
  crt_sync #(.STAGES(SYNC_STAGES)) u_syncEx (.clk(clk), .rstN(rstN), .din(t2exPin), .dout(exCur));

  tmrMode_e mode, modeNext;
  logic newRx, newTx, newCap, newRun, newDn, newOut;
  logic edgeMask, t2Strobe, exStrobe;
  logic isReload, isCapture, isBaud, isUpDown, isClkOut;
  logic tfSet, exSet, exToggle;

  always_comb begin
    mode     = decodeMode(rxSel, txSel, capSel, dnEn, outEn);
    newRx    = ctlWrEn  ? ctlWrData[CTL_RX]  : rxSel;
    newTx    = ctlWrEn  ? ctlWrData[CTL_TX]  : txSel;
    newCap   = ctlWrEn  ? ctlWrData[CTL_CAP] : capSel;
    newRun   = ctlWrEn  ? ctlWrData[CTL_RUN] : run;
    newDn    = modeWrEn ? modeWrData[MOD_DN]  : dnEn;
    newOut   = modeWrEn ? modeWrData[MOD_OUT] : outEn;
    modeNext = decodeMode(newRx, newTx, newCap, newDn, newOut);
    edgeMask = (modeNext != mode) || (newRun != run);
    t2Strobe = t2Prev & ~t2Cur & ~edgeMask;
    exStrobe = exPrev & ~exCur & ~edgeMask;

    isReload  = (mode == TM_RELOAD);
    isCapture = (mode == TM_CAPTURE);
    isBaud    = (mode == TM_BAUD);
    isUpDown  = (mode == TM_UPDOWN);
    isClkOut  = (mode == TM_CLKOUT);

    cmd.busLoad    = cntWrEn;
    cmd.extReload  = isReload  & extEn & exStrobe;
    cmd.extCapture = isCapture & extEn & exStrobe;
    cmd.step       = run & (cntSel ? t2Strobe : tick);
    cmd.fastStep   = ~cntSel & (isBaud | isClkOut);
    cmd.downDir    = isUpDown & ~exCur;
    cmd.wrapZero   = isCapture;

    tfSet    = (evt.ovf & (isReload | isCapture | isUpDown)) | evt.unf;
    exSet    = exStrobe & extEn & ~isUpDown;
    exToggle = isUpDown & (evt.ovf | evt.unf);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSel <= 1'b0; txSel <= 1'b0; extEn <= 1'b0; run <= 1'b0;
      cntSel <= 1'b0; capSel <= 1'b0; dnEn <= 1'b0; outEn <= 1'b0;
      t2Prev <= 1'b1; exPrev <= 1'b1;
      ovfFlag <= 1'b0; extFlag <= 1'b0;
      serialTick <= 1'b0; clkOut <= 1'b0;
    end else begin
      t2Prev <= t2Cur;
      exPrev <= exCur;
      if (ctlWrEn) begin
        rxSel  <= ctlWrData[CTL_RX];
        txSel  <= ctlWrData[CTL_TX];
        extEn  <= ctlWrData[CTL_EXEN];
        run    <= ctlWrData[CTL_RUN];
        cntSel <= ctlWrData[CTL_CNTSEL];
        capSel <= ctlWrData[CTL_CAP];
      end
      if (modeWrEn) begin
        dnEn  <= modeWrData[MOD_DN];
        outEn <= modeWrData[MOD_OUT];
      end
      if (tfSet)        ovfFlag <= 1'b1;
      else if (ctlWrEn) ovfFlag <= ctlWrData[CTL_OVF];
      if (exToggle)     extFlag <= ~extFlag;
      else if (exSet)   extFlag <= 1'b1;
      else if (ctlWrEn) extFlag <= ctlWrData[CTL_EXT];
      serialTick <= evt.ovf & (isBaud | isClkOut);
      if (evt.ovf & isClkOut & ~cntSel) clkOut <= ~clkOut;
    end
  end

  assign irq = irqEn & (ovfFlag | (extFlag & ~isUpDown));
endmodule

// File: rtl/capreload_timer.sv
module capreload_timer
  import capreload_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FAST_MULT   = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  input  logic             modeWrEn,
  input  logic [1:0]       modeWrData,
  input  logic             cntWrEn,
  input  logic [CNT_W-1:0] cntWrData,
  input  logic             capWrEn,
  input  logic [CNT_W-1:0] capWrData,
  input  logic             tick,
  input  logic             t2Pin,
  input  logic             t2exPin,
  input  logic             irqEn,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] capVal,
  output logic             ovfFlag,
  output logic             extFlag,
  output logic             serialTick,
  output logic             clkOut,
  output logic             irq
);
  dpCmd_t cmd;
  dpEvt_t evt;

  crt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .cntWrEn(cntWrEn),
    .tick(tick), .t2Pin(t2Pin), .t2exPin(t2exPin), .irqEn(irqEn),
    .evt(evt), .cmd(cmd), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .serialTick(serialTick), .clkOut(clkOut), .irq(irq)
  );

  crt_datapath #(.CNT_W(CNT_W), .FAST_MULT(FAST_MULT)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .busVal(cntWrData),
    .capWrEn(capWrEn), .capWrVal(capWrData),
    .count(count), .capVal(capVal), .evt(evt)
  );
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             ctlWrEn,
  input logic             wrRunBit,
  input logic             wrExtEnBit,
  input logic             modeWrEn,
  input logic             wrOutEnBit,
  input logic             cntWrEn,
  input logic             capWrEn,
  input logic             irqEn,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] capVal,
  input logic             ovfFlag,
  input logic             clkOut,
  input logic             irq
);
  logic runSh, extEnSh, outEnSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSh <= 1'b0; extEnSh <= 1'b0; outEnSh <= 1'b0;
    end else begin
      if (ctlWrEn) begin
        runSh   <= wrRunBit;
        extEnSh <= wrExtEnBit;
      end
      if (modeWrEn) outEnSh <= wrOutEnBit;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irq); // R13
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ctlWrEn) |=> ovfFlag); // R12
  AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!runSh && !extEnSh && !cntWrEn) |=> $stable(count)); // R11
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!capWrEn && !extEnSh) |=> $stable(capVal)); // R4
  AST_CLKOUT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !outEnSh |=> $stable(clkOut)); // R9
endmodule

bind capreload_timer crt_checker #(.CNT_W(CNT_W)) u_checker (
  .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn),
  .wrRunBit(ctlWrData[2]), .wrExtEnBit(ctlWrData[3]),
  .modeWrEn(modeWrEn), .wrOutEnBit(modeWrData[1]),
  .cntWrEn(cntWrEn), .capWrEn(capWrEn), .irqEn(irqEn),
  .count(count), .capVal(capVal), .ovfFlag(ovfFlag),
  .clkOut(clkOut), .irq(irq)
);

// File: tb/capreload_timer_bench.sv
module capreload_timer_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, ctlWrEn, modeWrEn, cntWrEn, capWrEn, tick, t2Pin, t2exPin, irqEn;
  logic [7:0] ctlWrData;
  logic [1:0] modeWrData;
  logic [15:0] cntWrData, capWrData, count, capVal;
  logic ovfFlag, extFlag, serialTick, clkOut, irq;

  capreload_timer u_capreload_timer (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .cntWrEn(cntWrEn),
    .cntWrData(cntWrData), .capWrEn(capWrEn), .capWrData(capWrData),
    .tick(tick), .t2Pin(t2Pin), .t2exPin(t2exPin), .irqEn(irqEn),
    .count(count), .capVal(capVal), .ovfFlag(ovfFlag), .extFlag(extFlag),
    .serialTick(serialTick), .clkOut(clkOut), .irq(irq)
  );

  typedef enum {S_COUNT, S_CAP, S_OVF, S_EXT, S_SER, S_CLK, S_IRQ} sel_e;
  typedef struct {
    sel_e        sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  event  chkEv;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  function automatic logic [15:0] probe(sel_e s);
    case (s)
      S_COUNT: return count;
      S_CAP:   return capVal;
      S_OVF:   return {15'd0, ovfFlag};
      S_EXT:   return {15'd0, extFlag};
      S_SER:   return {15'd0, serialTick};
      S_CLK:   return {15'd0, clkOut};
      default: return {15'd0, irq};
    endcase
  endfunction

  // Monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(chkEv);
      while (q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = q.pop_front();
        act = probe(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s actual %h expected %h", it.req, it.sel.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expectVal(sel_e s, logic [15:0] e, string r);
    q.push_back('{sel: s, exp: e, req: r});
    -> chkEv;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtl(logic [7:0] d);
    ctlWrEn = 1'b1; ctlWrData = d; cyc(1); ctlWrEn = 1'b0;
  endtask

  task automatic wrMode(logic [1:0] d);
    modeWrEn = 1'b1; modeWrData = d; cyc(1); modeWrEn = 1'b0;
  endtask

  task automatic wrCnt(logic [15:0] d);
    cntWrEn = 1'b1; cntWrData = d; cyc(1); cntWrEn = 1'b0;
  endtask

  task automatic wrCap(logic [15:0] d);
    capWrEn = 1'b1; capWrData = d; cyc(1); capWrEn = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) begin tick = 1'b1; cyc(1); tick = 1'b0; end
  endtask

  task automatic exFall; t2exPin = 1'b0; cyc(3); endtask
  task automatic exRise; t2exPin = 1'b1; cyc(3); endtask
  task automatic t2Pulse; t2Pin = 1'b0; cyc(3); t2Pin = 1'b1; cyc(3); endtask

  initial begin
    #2000000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ctlWrEn = 0; modeWrEn = 0; cntWrEn = 0; capWrEn = 0;
    ctlWrData = 0; modeWrData = 0; cntWrData = 0; capWrData = 0;
    tick = 0; t2Pin = 1; t2exPin = 1; irqEn = 1;
    cyc(3); rstN = 1'b1; cyc(1);

    // Reset state (R12 flags)
    expectVal(S_COUNT, 16'h0000, "R14 reset count");
    expectVal(S_CAP,   16'h0000, "R14 reset reload");
    expectVal(S_OVF,   16'h0000, "R12 reset ovf");
    expectVal(S_EXT,   16'h0000, "R12 reset ext");
    expectVal(S_IRQ,   16'h0000, "R13 reset irq");
    expectVal(S_CLK,   16'h0000, "R9 reset clkOut");

    // Auto-reload overflow (R2, R14, R13, R12)
    wrCap(16'h1234); expectVal(S_CAP, 16'h1234, "R14 reload write");
    wrCnt(16'hFFFE); expectVal(S_COUNT, 16'hFFFE, "R14 counter load");
    wrCtl(8'h04);
    step(1); expectVal(S_COUNT, 16'hFFFF, "R2 count up");
    expectVal(S_OVF, 16'h0000, "R2 no flag before wrap");
    step(1); expectVal(S_COUNT, 16'h1234, "R2 reload on overflow");
    expectVal(S_OVF, 16'h0001, "R2 overflow flag");
    expectVal(S_IRQ, 16'h0001, "R13 irq from overflow flag");
    wrCtl(8'h04);
    expectVal(S_OVF, 16'h0000, "R12 software clear");
    expectVal(S_IRQ, 16'h0000, "R13 irq drops");

    // Trigger reload (R3)
    wrCtl(8'h0C); wrCnt(16'h0500);
    exFall;
    expectVal(S_COUNT, 16'h1234, "R3 strobe reload");
    expectVal(S_EXT, 16'h0001, "R3 external flag");
    exRise;
    expectVal(S_COUNT, 16'h1234, "R3 rising edge no action");
    wrCtl(8'h0C); expectVal(S_EXT, 16'h0000, "R12 external clear");

    // Stopped timer (R11)
    wrCtl(8'h08); wrCnt(16'h0700);
    step(3); expectVal(S_COUNT, 16'h0700, "R11 no counting when stopped");
    exFall;
    expectVal(S_COUNT, 16'h1234, "R11 strobe reload while stopped");
    expectVal(S_EXT, 16'h0001, "R11 flag while stopped");
    exRise; wrCtl(8'h08);

    // Capture mode (R4, R1)
    wrCtl(8'h0D); wrCnt(16'hABCD);
    exFall;
    expectVal(S_CAP, 16'hABCD, "R4 capture copies counter");
    expectVal(S_EXT, 16'h0001, "R4 capture flag");
    expectVal(S_COUNT, 16'hABCD, "R4 counter unchanged by capture");
    exRise;
    wrCnt(16'hFFFF); step(1);
    expectVal(S_COUNT, 16'h0000, "R4 wraps to zero");
    expectVal(S_OVF, 16'h0001, "R4 overflow flag");

    // Flag priority (R12)
    wrCtl(8'h0D); expectVal(S_OVF, 16'h0000, "R12 clear before race");
    wrCnt(16'hFFFF);
    tick = 1'b1; ctlWrEn = 1'b1; ctlWrData = 8'h0D; cyc(1); tick = 1'b0; ctlWrEn = 1'b0;
    expectVal(S_OVF, 16'h0001, "R12 hardware set beats clear");
    wrCtl(8'h0D); wrCtl(8'h8D);
    expectVal(S_OVF, 16'h0001, "R12 software set");
    wrCtl(8'h0D);

    // Baud-rate mode (R5, R1)
    wrCap(16'h0010); wrCnt(16'hFFFC); wrCtl(8'h2C);
    step(1);
    expectVal(S_COUNT, 16'h0012, "R5 reload plus excess");
    expectVal(S_SER, 16'h0001, "R5 serial pulse");
    expectVal(S_OVF, 16'h0000, "R5 no overflow flag");
    cyc(1); expectVal(S_SER, 16'h0000, "R5 pulse one cycle");
    step(1); expectVal(S_COUNT, 16'h0018, "R5 six per tick");
    exFall;
    expectVal(S_EXT, 16'h0001, "R5 trigger sets flag");
    expectVal(S_COUNT, 16'h0018, "R5 trigger no reload");
    exRise;
    wrCtl(8'h1C); wrCnt(16'hFFFF); step(1);
    expectVal(S_COUNT, 16'h0015, "R1 transmit select gives baud mode");

    // Count-source pin (R6)
    wrCtl(8'h06); wrCnt(16'h0100);
    step(2); expectVal(S_COUNT, 16'h0100, "R6 ticks ignored");
    t2Pulse; t2Pulse;
    expectVal(S_COUNT, 16'h0102, "R6 one count per falling edge");

    // Up/down mode (R7, R8)
    wrMode(2'b01); wrCtl(8'h04); wrCap(16'h1000); wrCnt(16'h1001);
    t2exPin = 1'b0; cyc(3);
    expectVal(S_EXT, 16'h0000, "R7 trigger edge ignored");
    step(1); expectVal(S_COUNT, 16'h1000, "R7 count down");
    step(1);
    expectVal(S_COUNT, 16'hFFFF, "R7 underflow loads all ones");
    expectVal(S_OVF, 16'h0001, "R7 underflow flag");
    expectVal(S_EXT, 16'h0001, "R8 toggle on underflow");
    wrCtl(8'h44);
    expectVal(S_IRQ, 16'h0000, "R8 external flag excluded from irq");
    t2exPin = 1'b1; cyc(3);
    wrCnt(16'hFFFF); step(1);
    expectVal(S_COUNT, 16'h1000, "R7 up count reload");
    expectVal(S_EXT, 16'h0000, "R8 toggle back on overflow");

    // Clock-out mode (R9)
    wrCtl(8'h04); wrMode(2'b10); wrCap(16'hFFF0); wrCnt(16'hFFFE);
    step(1);
    expectVal(S_COUNT, 16'hFFF4, "R9 reload plus excess");
    expectVal(S_CLK, 16'h0001, "R9 toggle high");
    expectVal(S_SER, 16'h0001, "R9 serial pulse");
    expectVal(S_OVF, 16'h0000, "R9 no overflow flag");
    step(2);
    expectVal(S_COUNT, 16'hFFF0, "R9 second overflow");
    expectVal(S_CLK, 16'h0000, "R9 toggle low");
    wrCtl(8'h06); wrCnt(16'hFFFF); t2Pulse;
    expectVal(S_COUNT, 16'hFFF0, "R9 edge overflow reloads");
    expectVal(S_CLK, 16'h0000, "R9 no toggle with pin source");

    // Edge discarded on run change (R10)
    wrMode(2'b00); wrCtl(8'h09); wrCnt(16'h4242);
    t2exPin = 1'b0; cyc(2);
    ctlWrEn = 1'b1; ctlWrData = 8'h0D; cyc(1); ctlWrEn = 1'b0;
    expectVal(S_CAP, 16'hFFF0, "R10 masked strobe no capture");
    expectVal(S_EXT, 16'h0000, "R10 masked strobe no flag");
    exRise; exFall;
    expectVal(S_CAP, 16'h4242, "R10 later strobe captures");

    cyc(2); #1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule